// File: doc/BRIEF.md
# Serial Flash Chip-Erase Write-Control Sequencer

This block holds the write-control and status state of a serial NOR flash slave for the whole-array erase operation. An upstream shift engine decodes each opcode and presents it on `instr_valid_i`/`instr_code_i`. It also reports when chip select returns high (`cs_rise_i`) and whether that happened on a whole-byte boundary (`byte_aligned_i`). The sequencer holds the decoded command until that strobe and only then acts on it.

The sequencer keeps a write-enable latch and a busy flag. A write-enable command sets the latch and a write-disable command clears it. An erase command starts a self-timed countdown of `ERASE_CYCLES` clock cycles, but only when three conditions hold: the latch is set, all four protect bits on `bp_i` are zero, and no erase is already running. During the countdown the busy flag reads 1, and the status byte can be read at any time. When the countdown ends, the busy flag and the latch both clear together, and a one-cycle `erase_fire_o` pulse tells the memory model to blank the array.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, status_o reads zero in bits 1 and 0, and erase_fire_o is 0.
- R2: A write-enable command (code 0x06) sets status bit 1 (latch) in the cycle after the cs_rise_i strobe that closes it, when byte_aligned_i is 1.
- R3: A write-disable command (code 0x04), closed the same way, clears status bit 1.
- R4: A command whose cs_rise_i strobe comes with byte_aligned_i low is dropped and changes no status bit.
- R5: An erase command (code 0xC7), accepted with the latch set and bp_i equal to 0, sets status bit 0 (busy) in the cycle after the strobe. Busy then stays 1 for exactly ERASE_CYCLES clock cycles.
- R6: In the cycle busy returns to 0, the latch reads 0 and erase_fire_o is 1 for exactly that one cycle.
- R7: An erase command while any bit of bp_i is 1 is ignored: busy stays 0 and the latch keeps its value.
- R8: An erase command while the latch is 0 is ignored.
- R9: While busy is 1, write-enable, write-disable and erase commands are all ignored. The latch holds its value, and the running erase neither restarts nor stretches.
- R10: Status bits 5..2 show bp_i[3:0] at all times, including during an erase. Bits 7..6 read 0.
- R11: A decoded command has no effect until a cs_rise_i strobe arrives. A read-status command (0x05) or an unknown code changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | One-cycle pulse: instr_code_i holds a decoded opcode |
| instr_code_i | input | 8 | Decoded opcode |
| cs_rise_i | input | 1 | One-cycle pulse: chip select went high |
| byte_aligned_i | input | 1 | Chip select rose on a whole-byte boundary (valid with cs_rise_i) |
| bp_i | input | 4 | Block-protect field, bit 3 down to bit 0 |
| status_o | output | 8 | Status byte: bit 0 busy, bit 1 latch, bits 5..2 protect |
| erase_fire_o | output | 1 | One-cycle pulse when an erase completes |

## Verification
The hardest case to reach is a write-control command that arrives while an erase is already running, because it must leave both the latch and the countdown untouched. The bench starts an erase and then sends write-disable, write-enable and a second erase while busy is still 1. It checks the latch in the middle of the erase and counts the busy cycles to show they still equal ERASE_CYCLES. It also checks that exactly one completion pulse appears and that no second erase follows. Protect rejection is covered by setting each protect bit on its own in turn.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_WREN       = 8'h06;
  localparam logic [7:0] OP_WRDI       = 8'h04;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OP_RDSR       = 8'h05;

  localparam int SR_BUSY  = 0;
  localparam int SR_LATCH = 1;
  localparam int SR_BP_LO = 2;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SET_LATCH,
    ACT_CLR_LATCH,
    ACT_ERASE
  } act_e;
endpackage

// File: rtl/fes_cmd_latch.sv
module fes_cmd_latch
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid_i,
  input  logic [7:0] instr_code_i,
  input  logic       cs_rise_i,
  input  logic       byte_aligned_i,
  output act_e       act_o
);
  logic       pend_q, pend_d;
  logic [7:0] code_q, code_d;

  always_comb begin
    pend_d = pend_q;
    code_d = code_q;
    if (cs_rise_i) begin
      pend_d = 1'b0;
    end else if (instr_valid_i) begin
      pend_d = 1'b1;
      code_d = instr_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      code_q <= 8'h00;
    end else begin
      pend_q <= pend_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    act_o = ACT_NONE;
    if (cs_rise_i && byte_aligned_i && pend_q) begin
      case (code_q)
        OP_WREN:       act_o = ACT_SET_LATCH;
        OP_WRDI:       act_o = ACT_CLR_LATCH;
        OP_CHIP_ERASE: act_o = ACT_ERASE;
        default:       act_o = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fes_latch.sv
module fes_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/fes_erase_timer.sv
module fes_erase_timer #(
  parameter int unsigned ERASE_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic last_o,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d, fire_d;

  assign last_o = busy_o && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_o;
    fire_d = 1'b0;
    if (busy_o) begin
      if (last_o) begin
        busy_d = 1'b0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_o <= busy_d;
      fire_o <= fire_d;
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 1000000,
  parameter int unsigned BP_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid_i,
  input  logic [7:0]      instr_code_i,
  input  logic            cs_rise_i,
  input  logic            byte_aligned_i,
  input  logic [BP_W-1:0] bp_i,
  output logic [7:0]      status_o,
  output logic            erase_fire_o
);
  localparam int unsigned PAD_W = 8 - SR_BP_LO - BP_W;

  act_e act;
  logic busy, last, latch;
  logic latch_set, latch_clr, erase_go;

  fes_cmd_latch u_cmd (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid_i  (instr_valid_i),
    .instr_code_i   (instr_code_i),
    .cs_rise_i      (cs_rise_i),
    .byte_aligned_i (byte_aligned_i),
    .act_o          (act)
  );

  assign erase_go  = (act == ACT_ERASE) && latch && (bp_i == '0) && !busy;
  assign latch_set = (act == ACT_SET_LATCH) && !busy;
  assign latch_clr = ((act == ACT_CLR_LATCH) && !busy) || last;

  fes_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (latch_set),
    .clr_i (latch_clr),
    .q_o   (latch)
  );

  fes_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (erase_go),
    .busy_o  (busy),
    .last_o  (last),
    .fire_o  (erase_fire_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_o = {{PAD_W{1'b0}}, bp_i, latch, busy};
    end else begin : g_nopad
      assign status_o = {bp_i, latch, busy};
    end
  endgenerate
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int unsigned ERASE_CYCLES = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise_i,
  input logic       byte_aligned_i,
  input logic [3:0] bp_i,
  input logic [7:0] status_o,
  input logic       erase_fire_o
);
  logic busy, latch;
  int unsigned run_len;
  assign busy  = status_o[0];
  assign latch = status_o[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r5_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(latch) && $past(cs_rise_i && byte_aligned_i));
  a_r7_start_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bp_i) == 4'b0000);
  a_r5_duration: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == ERASE_CYCLES);
  a_r6_fire_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire_o |-> !busy && !latch && $past(busy));
  a_r6_end_fires: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> erase_fire_o);
  a_r9_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(latch));
  a_r2_latch_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $past(cs_rise_i && byte_aligned_i));
  a_r10_protect_view: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:2] == bp_i && status_o[7:6] == 2'b00);
endmodule

bind flash_erase_seq fes_checker #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs_rise_i      (cs_rise_i),
  .byte_aligned_i (byte_aligned_i),
  .bp_i           (bp_i),
  .status_o       (status_o),
  .erase_fire_o   (erase_fire_o)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int unsigned E = 20;

  logic       clk, rst_n;
  logic       instr_valid_i, cs_rise_i, byte_aligned_i;
  logic [7:0] instr_code_i;
  logic [3:0] bp_i;
  logic [7:0] status_o;
  logic       erase_fire_o;

  int checks = 0;
  int fails  = 0;
  int busy_cnt = 0;
  int fire_cnt = 0;

  flash_erase_seq #(.ERASE_CYCLES(E)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
    .instr_code_i(instr_code_i), .cs_rise_i(cs_rise_i),
    .byte_aligned_i(byte_aligned_i), .bp_i(bp_i),
    .status_o(status_o), .erase_fire_o(erase_fire_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (status_o[0])  busy_cnt <= busy_cnt + 1;
    if (erase_fire_o) fire_cnt <= fire_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] code, input logic aligned);
    @(negedge clk);
    instr_valid_i = 1'b1; instr_code_i = code;
    @(negedge clk);
    instr_valid_i = 1'b0; cs_rise_i = 1'b1; byte_aligned_i = aligned;
    @(negedge clk);
    cs_rise_i = 1'b0; byte_aligned_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (status_o[0]) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy", status_o[0], 0);
    check("R1 latch", status_o[1], 0);
    check("R1 fire", erase_fire_o, 0);
  endtask

  task automatic t_latch_cmds();
    issue(8'h06, 1'b1);
    check("R2 latch set", status_o[1], 1);
    issue(8'h05, 1'b1);
    check("R11 read-status no effect", status_o[1], 1);
    issue(8'h3C, 1'b1);
    check("R11 unknown code no effect", status_o[1], 1);
    issue(8'h04, 1'b1);
    check("R3 latch cleared", status_o[1], 0);
  endtask

  task automatic t_unaligned();
    issue(8'h06, 1'b0);
    check("R4 unaligned write-enable dropped", status_o[1], 0);
    issue(8'h06, 1'b1);
    issue(8'h04, 1'b0);
    check("R4 unaligned write-disable dropped", status_o[1], 1);
    issue(8'h04, 1'b1);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    instr_valid_i = 1'b1; instr_code_i = 8'h06;
    @(negedge clk);
    instr_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 no strobe no effect", status_o[1], 0);
    @(negedge clk);
    cs_rise_i = 1'b1; byte_aligned_i = 1'b0;
    @(negedge clk);
    cs_rise_i = 1'b0;
  endtask

  task automatic t_erase_ok();
    issue(8'h06, 1'b1);
    busy_cnt = 0; fire_cnt = 0;
    issue(8'hC7, 1'b1);
    check("R5 busy after strobe", status_o[0], 1);
    check("R10 protect bits during erase", status_o[5:2], 0);
    bp_i = 4'b1010;
    @(negedge clk);
    check("R10 protect view live", status_o[5:2], 4'b1010);
    check("R10 upper bits zero", status_o[7:6], 0);
    bp_i = 4'b0000;
    wait_idle();
    check("R6 fire at end", erase_fire_o, 1);
    check("R6 latch cleared at end", status_o[1], 0);
    check("R5 busy length", busy_cnt, E);
    @(negedge clk);
    check("R6 fire one cycle", erase_fire_o, 0);
  endtask

  task automatic t_busy_ignores();
    issue(8'h06, 1'b1);
    busy_cnt = 0; fire_cnt = 0;
    issue(8'hC7, 1'b1);
    issue(8'h04, 1'b1);
    check("R9 write-disable ignored while busy", status_o[1], 1);
    issue(8'hC7, 1'b1);
    issue(8'h06, 1'b1);
    check("R9 still busy", status_o[0], 1);
    wait_idle();
    check("R9 latch cleared only at end", status_o[1], 0);
    check("R9 length unchanged", busy_cnt, E);
    repeat (4) @(negedge clk);
    check("R9 no restart", status_o[0], 0);
    check("R9 single fire", fire_cnt, 1);
  endtask

  task automatic t_protected();
    for (int b = 0; b < 4; b++) begin
      bp_i = 4'(1 << b);
      issue(8'h06, 1'b1);
      issue(8'hC7, 1'b1);
      repeat (2) @(negedge clk);
      check("R7 protected erase ignored", status_o[0], 0);
      check("R7 latch kept", status_o[1], 1);
    end
    bp_i = 4'b0000;
    issue(8'h04, 1'b1);
  endtask

  task automatic t_no_latch();
    issue(8'hC7, 1'b1);
    repeat (2) @(negedge clk);
    check("R8 erase without latch ignored", status_o[0], 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid_i = 1'b0; instr_code_i = 8'h00;
    cs_rise_i = 1'b0; byte_aligned_i = 1'b0; bp_i = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_cmds();
    t_unaligned();
    t_no_strobe();
    t_erase_ok();
    t_busy_ignores();
    t_protected();
    t_no_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule